// File: doc/BRIEF.md
# Scatter-Gather DMA Channel Register File

This block holds the software-visible control and status state for a scatter-gather DMA engine that has several channels. Each channel has a control word, a status word, a current-descriptor pointer and a tail-descriptor pointer. All channels share one word-addressed bus window. The block passes run, halted and idle state to the descriptor engine. It gives channel 0 a one-cycle start pulse when software moves that channel's tail pointer. It takes set events from the engine for halted, idle and the two interrupt flags. It also takes the live completion-counter and delay-timer values, which appear in status reads.

Each channel drives one interrupt line. The line is high while an interrupt flag and the enable bit in the same position of the control word are both set. Software clears a flag by writing 1 to it. A soft reset written through the control word puts the channel back into its reset state. The reset bit then reads back once as clear, and that read also clears it in storage.

Reads return data one cycle after the read strobe. Writes take effect at the clock edge that samples them.

Top module: `dma_chan_csr`

## Requirements
- R1: The channel index is bit 0 of (byte address / 0x30), so address 0x60 aliases channel 0. Within a channel, the byte offset is address modulo 0x30. Control is at offset 0x00, status at 0x04, the current pointer at 0x08 and the tail pointer at 0x10. Other or misaligned offsets read 0 and ignore writes. Read data appears on the cycle after the read strobe.
- R2: Control bit 0 is run, bit 1 is tail-pointer mode and bit 2 is soft reset. Every control write stores bit 1 as 1, whatever the written value.
- R3: After reset, control reads 0x0001_0000 and status reads 0x0000_0001 (halted). Idle, run, start and irq are all 0.
- R4: A control write that sets bit 2 reinitialises the channel: control becomes 0x0001_0006, status becomes halted only, and run drops. The reset bit stays set until a control read. That read returns bit 2 as 0 and clears it. A control write made while the bit is still set reinitialises the channel again.
- R5: A control write with bit 0 set, made while no soft reset is pending, clears both halted and idle. run_o follows control bit 0.
- R6: A tail-pointer write clears idle. For channel 0 only, start_o is high for exactly the one cycle after the write.
- R7: A status read returns the stored bits 15:0 (bit 0 halted, bit 1 idle, bits 14:12 interrupt flags, with bit 12 complete and bit 13 delay). Bits 23:16 carry the live completion count and bits 31:24 the live delay count.
- R8: irq_o of a channel is high while any of status bits 14:12 is set together with control bit 14:12 in the same position.
- R9: Writing 1 to status bit 12 or 13 clears that flag. Other status bits written by software, halted and idle included, are ignored.
- R10: Engine set events set halted, idle and the flags. A set event wins over a software clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_rd_i | input | 1 | Read strobe |
| bus_wr_i | input | 1 | Write strobe |
| bus_addr_i | input | AW | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after the read |
| eng_set_halted_i | input | NCH | Engine sets halted, one bit per channel |
| eng_set_idle_i | input | NCH | Engine sets idle |
| eng_set_ioc_i | input | NCH | Engine sets the completion flag |
| eng_set_dly_i | input | NCH | Engine sets the delay flag |
| cmpl_cnt_i | input | NCH*8 | Live completion counters, 8 bits per channel |
| dly_cnt_i | input | NCH*8 | Live delay-timer counts, 8 bits per channel |
| run_o | output | NCH | Run bit of each channel |
| halted_o | output | NCH | Halted state |
| idle_o | output | NCH | Idle state |
| start_o | output | 1 | Start pulse for channel 0 |
| irq_o | output | NCH | Interrupt line per channel |

## Verification
On every cycle, the embedded assertions check these local rules: the tail-mode bit is stored by each control write, a soft reset leaves the channel halted and stopped, a control read drops the reset bit, a run write clears halted and idle, a written-1 clears its flag, and no channel other than 0 produces a start pulse. Only the bench scenarios can show the rest. That covers the address aliasing and the composition of the status word with live counters. It also covers the two-step soft reset, in which a run write is swallowed until the reset bit has been read. The interrupt masking, the same-cycle set-versus-clear priority and the independence of the two channels are bench-only too.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned CNT_W = 8;

  // word index within a channel
  localparam int unsigned W_CTRL = 0;
  localparam int unsigned W_STAT = 1;
  localparam int unsigned W_CUR  = 2;
  localparam int unsigned W_TAIL = 4;

  // control bits
  localparam int unsigned C_RUN  = 0;
  localparam int unsigned C_TAIL = 1;
  localparam int unsigned C_RST  = 2;
  localparam int unsigned IRQ_LO = 12;
  localparam int unsigned IRQ_HI = 14;

  localparam logic [DW-1:0] CTRL_INIT = 32'h0001_0000;
  localparam logic [DW-1:0] CTRL_SOFT = 32'h0001_0006;

  typedef struct packed {
    logic ctrl;
    logic stat;
    logic cur;
    logic tail;
  } wsel_t;
endpackage

// File: rtl/dma_csr_dec.sv
module dma_csr_dec
  import dma_csr_pkg::*;
#(
  parameter int unsigned AW     = 8,
  parameter int unsigned NCH    = 2,
  parameter int unsigned SPAN_B = 48,
  localparam int unsigned CH_W  = $clog2(NCH)
) (
  input  logic [AW-1:0]   addr_i,
  output logic [CH_W-1:0] ch_o,
  output wsel_t           sel_o
);
  logic [AW-1:0] off;
  logic [AW-1:0] blk;
  logic [AW-3:0] word;
  logic          aligned;

  assign off     = addr_i % AW'(SPAN_B);
  assign blk     = addr_i / AW'(SPAN_B);
  assign ch_o    = blk[CH_W-1:0];
  assign word    = off[AW-1:2];
  assign aligned = (off[1:0] == 2'b00);

  always_comb begin
    sel_o      = '0;
    sel_o.ctrl = aligned && (word == (AW-2)'(W_CTRL));
    sel_o.stat = aligned && (word == (AW-2)'(W_STAT));
    sel_o.cur  = aligned && (word == (AW-2)'(W_CUR));
    sel_o.tail = aligned && (word == (AW-2)'(W_TAIL));
  end

  logic unused_blk;
  assign unused_blk = ^blk[AW-1:CH_W];
endmodule

// File: rtl/dma_csr_chan.sv
module dma_csr_chan
  import dma_csr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             rd_i,
  input  wsel_t            sel_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             set_halted_i,
  input  logic             set_idle_i,
  input  logic             set_ioc_i,
  input  logic             set_dly_i,
  input  logic [CNT_W-1:0] cmpl_cnt_i,
  input  logic [CNT_W-1:0] dly_cnt_i,
  output logic [DW-1:0]    rdata_o,
  output logic             run_o,
  output logic             halted_o,
  output logic             idle_o,
  output logic             irq_o
);
  localparam int unsigned NFL = IRQ_HI - IRQ_LO + 1;

  logic [DW-1:0]  ctrl_q, ctrl_d, ctrl_new;
  logic [DW-1:0]  cur_q, tail_q;
  logic           halted_q, halted_d, idle_q, idle_d;
  logic [NFL-1:0] flag_q, flag_d, flag_set;
  logic           ctrl_wr, stat_wr;

  assign ctrl_wr  = wr_i && sel_i.ctrl;
  assign stat_wr  = wr_i && sel_i.stat;
  assign flag_set = {1'b0, set_dly_i, set_ioc_i};

  always_comb begin
    ctrl_new        = wdata_i;
    ctrl_new[C_TAIL] = 1'b1;
    ctrl_new[C_RST]  = wdata_i[C_RST] | ctrl_q[C_RST];
  end

  always_comb begin
    ctrl_d   = ctrl_q;
    halted_d = halted_q;
    idle_d   = idle_q;
    flag_d   = flag_q;
    if (rd_i && sel_i.ctrl) ctrl_d[C_RST] = 1'b0;
    if (ctrl_wr) begin
      if (ctrl_new[C_RST]) begin
        ctrl_d   = CTRL_SOFT;
        halted_d = 1'b1;
        idle_d   = 1'b0;
        flag_d   = '0;
      end else begin
        ctrl_d = ctrl_new;
        if (ctrl_new[C_RUN]) begin
          halted_d = 1'b0;
          idle_d   = 1'b0;
        end
      end
    end
    if (stat_wr) flag_d = flag_q & ~wdata_i[IRQ_HI:IRQ_LO];
    if (wr_i && sel_i.tail) idle_d = 1'b0;
    // engine set events win over software clears
    if (set_halted_i) halted_d = 1'b1;
    if (set_idle_i)   idle_d   = 1'b1;
    flag_d = flag_d | flag_set;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= CTRL_INIT;
      halted_q <= 1'b1;
      idle_q   <= 1'b0;
      flag_q   <= '0;
      cur_q    <= '0;
      tail_q   <= '0;
    end else begin
      ctrl_q   <= ctrl_d;
      halted_q <= halted_d;
      idle_q   <= idle_d;
      flag_q   <= flag_d;
      if (wr_i && sel_i.cur)  cur_q  <= wdata_i;
      if (wr_i && sel_i.tail) tail_q <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (1'b1)
      sel_i.ctrl: begin
        rdata_o        = ctrl_q;
        rdata_o[C_RST] = 1'b0;
      end
      sel_i.stat: begin
        rdata_o[0]              = halted_q;
        rdata_o[1]              = idle_q;
        rdata_o[IRQ_HI:IRQ_LO]  = flag_q;
        rdata_o[23:16]          = cmpl_cnt_i;
        rdata_o[31:24]          = dly_cnt_i;
      end
      sel_i.cur:  rdata_o = cur_q;
      sel_i.tail: rdata_o = tail_q;
      default:    rdata_o = '0;
    endcase
  end

  assign run_o    = ctrl_q[C_RUN];
  assign halted_o = halted_q;
  assign idle_o   = idle_q;
  assign irq_o    = |(flag_q & ctrl_q[IRQ_HI:IRQ_LO]);

  // R2
  tail_mode_forced_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr |=> ctrl_q[C_TAIL]);
  // R4
  soft_rst_halt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && ctrl_new[C_RST] && !set_idle_i) |=> (halted_q && !run_o && !idle_q));
  // R4
  rst_clear_on_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && sel_i.ctrl && !ctrl_wr) |=> !ctrl_q[C_RST]);
  // R5
  run_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && !ctrl_q[C_RST] && wdata_i[C_RUN] && !wdata_i[C_RST]
     && !set_halted_i && !set_idle_i) |=> (!halted_q && !idle_q && run_o));
  // R9
  flag_w1c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_wr && wdata_i[IRQ_LO] && !set_ioc_i) |=> !flag_q[0]);
endmodule

// File: rtl/dma_chan_csr.sv
module dma_chan_csr
  import dma_csr_pkg::*;
#(
  parameter int unsigned AW     = 8,
  parameter int unsigned NCH    = 2,
  parameter int unsigned SPAN_B = 48,
  localparam int unsigned CH_W  = $clog2(NCH)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bus_rd_i,
  input  logic               bus_wr_i,
  input  logic [AW-1:0]      bus_addr_i,
  input  logic [DW-1:0]      bus_wdata_i,
  output logic [DW-1:0]      bus_rdata_o,
  input  logic [NCH-1:0]     eng_set_halted_i,
  input  logic [NCH-1:0]     eng_set_idle_i,
  input  logic [NCH-1:0]     eng_set_ioc_i,
  input  logic [NCH-1:0]     eng_set_dly_i,
  input  logic [NCH*CNT_W-1:0] cmpl_cnt_i,
  input  logic [NCH*CNT_W-1:0] dly_cnt_i,
  output logic [NCH-1:0]     run_o,
  output logic [NCH-1:0]     halted_o,
  output logic [NCH-1:0]     idle_o,
  output logic               start_o,
  output logic [NCH-1:0]     irq_o
);
  logic [CH_W-1:0]          dec_ch;
  wsel_t                    dec_sel;
  logic [NCH-1:0][DW-1:0]   chan_rdata;
  logic [DW-1:0]            rdata_q;
  logic                     start_q;

  dma_csr_dec #(.AW(AW), .NCH(NCH), .SPAN_B(SPAN_B)) u_dec (
    .addr_i (bus_addr_i),
    .ch_o   (dec_ch),
    .sel_o  (dec_sel)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic hit;
    assign hit = (dec_ch == CH_W'(i));
    dma_csr_chan u_chan (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .wr_i         (bus_wr_i && hit),
      .rd_i         (bus_rd_i && hit),
      .sel_i        (dec_sel),
      .wdata_i      (bus_wdata_i),
      .set_halted_i (eng_set_halted_i[i]),
      .set_idle_i   (eng_set_idle_i[i]),
      .set_ioc_i    (eng_set_ioc_i[i]),
      .set_dly_i    (eng_set_dly_i[i]),
      .cmpl_cnt_i   (cmpl_cnt_i[i*CNT_W +: CNT_W]),
      .dly_cnt_i    (dly_cnt_i[i*CNT_W +: CNT_W]),
      .rdata_o      (chan_rdata[i]),
      .run_o        (run_o[i]),
      .halted_o     (halted_o[i]),
      .idle_o       (idle_o[i]),
      .irq_o        (irq_o[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      start_q <= 1'b0;
    end else begin
      if (bus_rd_i) rdata_q <= chan_rdata[dec_ch];
      start_q <= bus_wr_i && dec_sel.tail && (dec_ch == '0);
    end
  end

  assign bus_rdata_o = rdata_q;
  assign start_o     = start_q;

  // R6
  start_ch0_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && dec_sel.tail && dec_ch != '0) |=> !start_o);
  // R6
  start_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o && !(bus_wr_i && dec_sel.tail && dec_ch == '0)) |=> !start_o);
endmodule

// File: tb/dma_chan_csr_bench.sv
module dma_chan_csr_bench;
  localparam int AW = 8;
  localparam int NCH = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd = 1'b0, wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NCH-1:0] s_halt = '0, s_idle = '0, s_ioc = '0, s_dly = '0;
  logic [NCH*8-1:0] cmpl = '0, dly = '0;
  logic [NCH-1:0] run, halted, idle, irq;
  logic start;

  int n_tests = 0, n_fail = 0;
  logic rd_d = 1'b0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  dma_chan_csr u_dma_chan_csr (
    .clk_i(clk), .rst_ni(rst_n), .bus_rd_i(rd), .bus_wr_i(wr),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .eng_set_halted_i(s_halt), .eng_set_idle_i(s_idle),
    .eng_set_ioc_i(s_ioc), .eng_set_dly_i(s_dly),
    .cmpl_cnt_i(cmpl), .dly_cnt_i(dly),
    .run_o(run), .halted_o(halted), .idle_o(idle),
    .start_o(start), .irq_o(irq)
  );

  always @(posedge clk) rd_d <= rd;

  // monitor: pop expected read data
  always @(negedge clk) begin
    if (rd_d) begin
      n_tests++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL read with no expectation: act=%08h", rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rdata !== e) begin
          n_fail++;
          $display("FAIL %s: act=%08h exp=%08h", t, rdata, e);
        end
      end
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string t);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act=%0h exp=%0h", t, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [AW-1:0] a, input logic [31:0] e, input string t);
    @(negedge clk); rd = 1'b1; addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); rd = 1'b0;
  endtask

  // kind: 0 halted, 1 idle, 2 ioc, 3 dly
  task automatic evt(input int ch, input int kind);
    @(negedge clk);
    case (kind)
      0: s_halt[ch] = 1'b1;
      1: s_idle[ch] = 1'b1;
      2: s_ioc[ch]  = 1'b1;
      default: s_dly[ch] = 1'b1;
    endcase
    @(negedge clk); s_halt = '0; s_idle = '0; s_ioc = '0; s_dly = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: act=timeout exp=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R3 reset state
    chk(halted, 2'b11, "R3 halted");
    chk(idle, 2'b00, "R3 idle");
    chk(run, 2'b00, "R3 run");
    chk({irq, start}, 3'b000, "R3 irq/start");
    bus_rd(8'h00, 32'h0001_0000, "R3 ctrl ch0");
    bus_rd(8'h30, 32'h0001_0000, "R3 ctrl ch1");
    // R7 live counters
    cmpl[7:0] = 8'h05; dly[7:0] = 8'h09;
    bus_rd(8'h04, 32'h0905_0001, "R7 status composition");
    cmpl = '0; dly = '0;
    bus_rd(8'h08, 32'h0, "R1 cur reset");
    bus_rd(8'h0C, 32'h0, "R1 unused word");
    // R5 run, R2 tail forced
    bus_wr(8'h00, 32'h0000_1001);
    chk(run, 2'b01, "R5 run");
    chk(halted, 2'b10, "R5 halted cleared");
    bus_rd(8'h00, 32'h0000_1003, "R2 tail mode forced");
    // R8/R10 ioc flag
    evt(0, 2);
    chk(irq, 2'b01, "R8 irq on ioc");
    bus_rd(8'h04, 32'h0000_1000, "R10 ioc set");
    // R9 ignored bits then W1C
    bus_wr(8'h04, 32'h0000_0003);
    chk(halted, 2'b10, "R9 halted not writable");
    bus_rd(8'h04, 32'h0000_1000, "R9 non-flag ignored");
    bus_wr(8'h04, 32'h0000_1000);
    chk(irq, 2'b00, "R9 irq cleared");
    bus_rd(8'h04, 32'h0, "R9 flag cleared");
    // R6 tail write
    evt(0, 1);
    chk(idle, 2'b01, "R10 idle set");
    bus_wr(8'h10, 32'h0000_0040);
    chk(start, 1'b1, "R6 start pulse");
    chk(idle, 2'b00, "R6 idle cleared");
    @(negedge clk);
    chk(start, 1'b0, "R6 pulse one cycle");
    bus_rd(8'h10, 32'h40, "R1 tail readback");
    bus_wr(8'h08, 32'h0000_0020);
    bus_rd(8'h08, 32'h20, "R1 cur readback");
    // R8 masked flag
    evt(0, 3);
    chk(irq, 2'b00, "R8 dly masked");
    bus_rd(8'h04, 32'h0000_2000, "R10 dly set");
    // R10 set beats clear in same cycle
    @(negedge clk); wr = 1'b1; addr = 8'h04; wdata = 32'h0000_2000; s_dly[0] = 1'b1;
    @(negedge clk); wr = 1'b0; s_dly = '0;
    bus_rd(8'h04, 32'h0000_2000, "R10 set wins over clear");
    // R4 soft reset
    bus_wr(8'h00, 32'h0000_0004);
    chk(halted, 2'b11, "R4 halted after soft reset");
    chk(run, 2'b00, "R4 run dropped");
    bus_wr(8'h00, 32'h0000_0001);
    chk(halted, 2'b11, "R4 run swallowed while reset pending");
    chk(run, 2'b00, "R4 run stays low");
    bus_rd(8'h04, 32'h0000_0001, "R4 status reinit");
    bus_rd(8'h00, 32'h0001_0002, "R4 reset bit reads clear");
    bus_wr(8'h00, 32'h0000_0001);
    chk(run, 2'b01, "R5 run after reset read");
    chk(halted, 2'b10, "R5 halted cleared again");
    bus_rd(8'h00, 32'h0000_0003, "R4 reset bit gone");
    bus_rd(8'h60, 32'h0000_0003, "R1 alias to ch0");
    // channel 1
    bus_wr(8'h30, 32'h0000_2001);
    chk(run, 2'b11, "R5 ch1 run");
    chk(halted, 2'b00, "R5 ch1 halted cleared");
    bus_wr(8'h40, 32'h0000_0080);
    chk(start, 1'b0, "R6 no start for ch1");
    bus_rd(8'h40, 32'h80, "R1 ch1 tail");
    bus_rd(8'h10, 32'h40, "R1 ch0 tail untouched");
    evt(1, 3);
    chk(irq, 2'b10, "R8 ch1 dly irq");
    evt(1, 0);
    chk(halted, 2'b10, "R10 ch1 halted set");
    bus_rd(8'h34, 32'h0000_2001, "R7 ch1 status");
    repeat (2) @(negedge clk);
    chk(exp_q.size(), 0, "R1 all reads returned");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule